// File: doc/BRIEF.md
# Striped Cache-Miss Fetch Dispatcher

When a read misses the cache, this block turns the single starting sector address into eight fetch commands. It sends one command to each of eight flash row DMA engines. The fetch window is eight allocation blocks long. It starts at the requested address, rounded down to an allocation-block boundary. Allocation block k of the window goes to row k, so all eight rows can transfer at the same time on their own buses.

Each command carries three fields:
- the first sector of the row's allocation block;
- its length in sectors;
- the sector offset, inside the receiving cache page, where that block lands. A cache page holds one allocation block from each row.

The allocation-block size is a small power-of-two code. It is sampled when the request is accepted, so it can change between requests. The block takes one request at a time. It waits until every row has reported completion, then raises a one-cycle done pulse, or an error pulse if any row failed.

Top module: `miss_stripe_dispatch`

## Requirements
- R1: The allocation-block length is 4 << c sectors, where c is the effective code. Codes 0..3 give 4, 8, 16 and 32 sectors (2 KB to 16 KB at 512 bytes per sector). Codes 4..7 act as code 3.
- R2: The window base is the requested sector address with its low log2(length) bits cleared.
- R3: Row r (0..7) is commanded with first sector base + r*length and with length sectors. The address arithmetic wraps modulo 2^32.
- R4: In the cycle after a request is accepted, all eight command valids are high. Each row's valid stays high, with its fields unchanged, until that row's ready is seen at a clock edge. It then drops.
- R5: req_ready_o is low from acceptance until the result pulse. A request, or a change of code, presented during that time has no effect on the commands in flight.
- R6: When no row reported an error, done_o is high for exactly one cycle. That cycle starts at the second rising edge after the last completion is presented. req_ready_o returns high in the same cycle.
- R7: When any row's completion carried cpl_err_i, err_o pulses in place of done_o, with the same timing.
- R8: Row r's cache slot offset is r*length sectors within an eight-block page.
- R9: A completion on a row whose command has not yet been accepted is ignored. So is a completion on a row that has already finished.
- R10: After reset, req_ready_o is high, and no command valid, done_o or err_o is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Miss request valid |
| req_ready_o | output | 1 | Dispatcher idle, request can be taken |
| req_lba_i | input | 32 | Requested starting sector address |
| ab_code_i | input | 3 | Allocation-block size code |
| cmd_valid_o | output | 8 | Per-row command valid |
| cmd_ready_i | input | 8 | Per-row command accepted by DMA engine |
| cmd_lba_o | output | 256 | Per-row first sector, row r at bits [32r+31:32r] |
| cmd_len_o | output | 48 | Per-row sector count, row r at bits [6r+5:6r] |
| cmd_slot_o | output | 64 | Per-row sector offset in cache page, row r at bits [8r+7:8r] |
| cpl_valid_i | input | 8 | Per-row completion strobe |
| cpl_err_i | input | 8 | Per-row completion error, qualified by cpl_valid_i |
| done_o | output | 1 | One-cycle pulse: all rows completed cleanly |
| err_o | output | 1 | One-cycle pulse: all rows completed, at least one failed |

## Verification
Some checks run on every cycle:
- the first row's command address sits on an allocation-block boundary;
- neighbouring row addresses differ by exactly one block length;
- a pending command holds its valid and its address until accepted;
- no request is accepted while any command is pending;
- a completion arriving before the row issued does not finish that row;
- done_o never lasts two cycles.

Only the bench scenarios can show the rest:
- the exact addresses and slot offsets for unaligned, wrapping and out-of-range-code requests;
- the cycle in which done_o or err_o fires after staggered completions;
- that a code change or a request made while busy leaves the commands in flight unchanged.

// File: rtl/msd_pkg.sv
package msd_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_BUSY
  } msd_state_e;

  typedef enum logic [1:0] {
    RS_IDLE,
    RS_ISSUE,
    RS_WAIT,
    RS_DONE
  } msd_row_state_e;

endpackage

// File: rtl/msd_stripe_calc.sv
module msd_stripe_calc #(
  parameter int unsigned N_ROWS   = 8,
  parameter int unsigned LBA_W    = 32,
  parameter int unsigned MIN_LOG2 = 2,
  parameter int unsigned MAX_CODE = 3,
  localparam int unsigned ECODE_W = (MAX_CODE < 1) ? 1 : $clog2(MAX_CODE + 1),
  localparam int unsigned LEN_W   = MIN_LOG2 + MAX_CODE + 1,
  localparam int unsigned ROW_W   = (N_ROWS < 2) ? 1 : $clog2(N_ROWS),
  localparam int unsigned SLOT_W  = ROW_W + MIN_LOG2 + MAX_CODE
) (
  input  logic [LBA_W-1:0]         base_i,
  input  logic [ECODE_W-1:0]       code_i,
  output logic [N_ROWS*LBA_W-1:0]  lba_o,
  output logic [N_ROWS*LEN_W-1:0]  len_o,
  output logic [N_ROWS*SLOT_W-1:0] slot_o
);

  localparam int unsigned SH_W = $clog2(MIN_LOG2 + MAX_CODE + 1);

  logic [SH_W-1:0]  sh;
  logic [LEN_W-1:0] len;

  assign sh  = SH_W'(MIN_LOG2) + SH_W'(code_i);
  assign len = LEN_W'(1) << sh;

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    assign lba_o[r*LBA_W +: LBA_W]    = base_i + (LBA_W'(r) << sh);
    assign len_o[r*LEN_W +: LEN_W]    = len;
    assign slot_o[r*SLOT_W +: SLOT_W] = SLOT_W'(r) << sh;
  end

endmodule

// File: rtl/msd_row_track.sv
module msd_row_track
  import msd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cmd_ready_i,
  input  logic cpl_valid_i,
  input  logic cpl_err_i,
  output logic cmd_valid_o,
  output logic fin_o,
  output logic err_o
);

  msd_row_state_e state_q;
  logic           err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RS_IDLE;
      err_q   <= 1'b0;
    end else if (start_i) begin
      state_q <= RS_ISSUE;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        RS_ISSUE: if (cmd_ready_i) state_q <= RS_WAIT;
        RS_WAIT: if (cpl_valid_i) begin
          state_q <= RS_DONE;
          err_q   <= cpl_err_i;
        end
        default: ;
      endcase
    end
  end

  assign cmd_valid_o = (state_q == RS_ISSUE);
  assign fin_o       = (state_q == RS_DONE);
  assign err_o       = err_q;

  // R4: command held until accepted
  p_hold_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> cmd_valid_o);

  // R9: early completion cannot finish the row
  p_early_cpl_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cpl_valid_i && !start_i) |=> !fin_o);

endmodule

// File: rtl/miss_stripe_dispatch.sv
module miss_stripe_dispatch
  import msd_pkg::*;
#(
  parameter int unsigned N_ROWS   = 8,
  parameter int unsigned LBA_W    = 32,
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned MIN_LOG2 = 2,
  parameter int unsigned MAX_CODE = 3,
  localparam int unsigned ECODE_W = (MAX_CODE < 1) ? 1 : $clog2(MAX_CODE + 1),
  localparam int unsigned LEN_W   = MIN_LOG2 + MAX_CODE + 1,
  localparam int unsigned ROW_W   = (N_ROWS < 2) ? 1 : $clog2(N_ROWS),
  localparam int unsigned SLOT_W  = ROW_W + MIN_LOG2 + MAX_CODE
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [LBA_W-1:0]         req_lba_i,
  input  logic [CODE_W-1:0]        ab_code_i,
  output logic [N_ROWS-1:0]        cmd_valid_o,
  input  logic [N_ROWS-1:0]        cmd_ready_i,
  output logic [N_ROWS*LBA_W-1:0]  cmd_lba_o,
  output logic [N_ROWS*LEN_W-1:0]  cmd_len_o,
  output logic [N_ROWS*SLOT_W-1:0] cmd_slot_o,
  input  logic [N_ROWS-1:0]        cpl_valid_i,
  input  logic [N_ROWS-1:0]        cpl_err_i,
  output logic                     done_o,
  output logic                     err_o
);

  localparam int unsigned SH_W = $clog2(MIN_LOG2 + MAX_CODE + 1);

  msd_state_e         state_q;
  logic [LBA_W-1:0]   base_q;
  logic [ECODE_W-1:0] code_q;
  logic               done_q, err_q;

  logic [ECODE_W-1:0] code_eff;
  logic [SH_W-1:0]    sh_acc;
  logic [LBA_W-1:0]   base_acc;
  logic               start;
  logic [N_ROWS-1:0]  row_fin, row_err;
  logic               all_fin;

  // out-of-range codes saturate at the largest block
  assign code_eff = (ab_code_i > CODE_W'(MAX_CODE)) ? ECODE_W'(MAX_CODE)
                                                    : ab_code_i[ECODE_W-1:0];
  assign sh_acc   = SH_W'(MIN_LOG2) + SH_W'(code_eff);
  assign base_acc = req_lba_i & ({LBA_W{1'b1}} << sh_acc);

  assign req_ready_o = (state_q == ST_IDLE);
  assign start       = req_valid_i && req_ready_o;
  assign all_fin     = &row_fin;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      code_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          base_q  <= base_acc;
          code_q  <= code_eff;
          state_q <= ST_BUSY;
        end
        ST_BUSY: if (all_fin) begin
          done_q  <= ~|row_err;
          err_q   <= |row_err;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;

  msd_stripe_calc #(
    .N_ROWS  (N_ROWS),
    .LBA_W   (LBA_W),
    .MIN_LOG2(MIN_LOG2),
    .MAX_CODE(MAX_CODE)
  ) u_calc (
    .base_i(base_q),
    .code_i(code_q),
    .lba_o (cmd_lba_o),
    .len_o (cmd_len_o),
    .slot_o(cmd_slot_o)
  );

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    msd_row_track u_track (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start),
      .cmd_ready_i(cmd_ready_i[r]),
      .cpl_valid_i(cpl_valid_i[r]),
      .cpl_err_i  (cpl_err_i[r]),
      .cmd_valid_o(cmd_valid_o[r]),
      .fin_o      (row_fin[r]),
      .err_o      (row_err[r])
    );

    // R4: fields stable while waiting
    p_hold_lba_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_o[r] && !cmd_ready_i[r]) |=> $stable(cmd_lba_o[r*LBA_W +: LBA_W]));

    if (r > 0) begin : g_nb
      // R3: neighbouring rows one block apart
      p_stripe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_valid_o[r] |-> (cmd_lba_o[r*LBA_W +: LBA_W] - cmd_lba_o[(r-1)*LBA_W +: LBA_W])
                           == LBA_W'(cmd_len_o[r*LEN_W +: LEN_W]));
    end
  end

  // R2: window base on block boundary
  p_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o[0] |-> ((cmd_lba_o[LBA_W-1:0] & (LBA_W'(cmd_len_o[LEN_W-1:0]) - 1'b1)) == '0));

  // R5: no acceptance while commands pending
  p_no_accept_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cmd_valid_o) |-> !req_ready_o);

  // R6: single-cycle done
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

// File: tb/tb_miss_stripe_dispatch.sv
module tb_miss_stripe_dispatch;

  localparam int N  = 8;
  localparam int AW = 32;
  localparam int LW = 6;
  localparam int SW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [AW-1:0]   req_lba = '0;
  logic [2:0]      ab_code = '0;
  logic [N-1:0]    cmd_valid;
  logic [N-1:0]    cmd_ready = '0;
  logic [N*AW-1:0] cmd_lba;
  logic [N*LW-1:0] cmd_len;
  logic [N*SW-1:0] cmd_slot;
  logic [N-1:0]    cpl_valid = '0;
  logic [N-1:0]    cpl_err = '0;
  logic            done, err;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  miss_stripe_dispatch dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_lba_i(req_lba), .ab_code_i(ab_code),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_lba_o(cmd_lba), .cmd_len_o(cmd_len), .cmd_slot_o(cmd_slot),
    .cpl_valid_i(cpl_valid), .cpl_err_i(cpl_err),
    .done_o(done), .err_o(err)
  );

  typedef struct packed {
    logic [31:0] lba;
    logic [2:0]  code;
    logic [31:0] base;
    logic [5:0]  len;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{lba: 32'h0000_0000, code: 3'd1, base: 32'h0000_0000, len: 6'd8},
    '{lba: 32'h1234_5677, code: 3'd0, base: 32'h1234_5674, len: 6'd4},
    '{lba: 32'h0000_003F, code: 3'd3, base: 32'h0000_0020, len: 6'd32},
    '{lba: 32'hFFFF_FFF9, code: 3'd2, base: 32'hFFFF_FFF0, len: 6'd16},
    '{lba: 32'h0000_0105, code: 3'd6, base: 32'h0000_0100, len: 6'd32},
    '{lba: 32'h0000_0010, code: 3'd4, base: 32'h0000_0000, len: 6'd32},
    '{lba: 32'h0000_002A, code: 3'd7, base: 32'h0000_0020, len: 6'd32}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [31:0] lba, input logic [2:0] code);
    req_valid = 1'b1;
    req_lba   = lba;
    ab_code   = code;
    step();
    req_valid = 1'b0;
  endtask

  task automatic chk_rows(input string req, input logic [31:0] base, input logic [5:0] len);
    for (int r = 0; r < N; r++) begin
      chk({req, " lba"}, cmd_lba[r*AW +: AW], base + 32'(r) * 32'(len));
      chk({req, " len"}, 32'(cmd_len[r*LW +: LW]), 32'(len));
      chk({req, " slot R8"}, 32'(cmd_slot[r*SW +: SW]), 32'(r) * 32'(len));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1;
    step();
    // R10: reset state
    chk("R10 ready", 32'(req_ready), 32'd1);
    chk("R10 valid", 32'(cmd_valid), 32'd0);
    chk("R10 done", 32'(done), 32'd0);
    chk("R10 err", 32'(err), 32'd0);
    rst_n = 1'b1;
    step();

    // R1 R2 R3 R4 R6 R8: vector walk
    foreach (VECS[i]) begin
      send(VECS[i].lba, VECS[i].code);
      chk("R5 busy", 32'(req_ready), 32'd0);
      chk("R4 all valid", 32'(cmd_valid), 32'hFF);
      chk_rows("R1 R2 R3", VECS[i].base, VECS[i].len);
      cmd_ready = '1;
      step();
      cmd_ready = '0;
      chk("R4 valid drop", 32'(cmd_valid), 32'd0);
      cpl_valid = '1;
      step();
      cpl_valid = '0;
      chk("R6 not early", 32'(done), 32'd0);
      step();
      chk("R6 done", 32'(done), 32'd1);
      chk("R6 ready back", 32'(req_ready), 32'd1);
      chk("R7 no err", 32'(err), 32'd0);
      step();
      chk("R6 pulse width", 32'(done), 32'd0);
    end

    // R4 R5 R9: staggered issue, early completions, busy changes
    send(32'h0000_0400, 3'd1);
    cmd_ready = 8'h08;
    chk("R4 all valid", 32'(cmd_valid), 32'hFF);
    step();
    chk("R4 row3 dropped", 32'(cmd_valid), 32'hF7);
    cmd_ready = '0;
    req_valid = 1'b1;
    req_lba   = 32'h0;
    ab_code   = 3'd0;
    cpl_valid = '1;
    step();
    cpl_valid = '0;
    req_valid = 1'b0;
    chk("R5 ready low", 32'(req_ready), 32'd0);
    chk("R5 row0 kept", cmd_lba[0 +: AW], 32'h0000_0400);
    chk("R5 row1 kept", cmd_lba[AW +: AW], 32'h0000_0408);
    chk("R9 pending kept", 32'(cmd_valid), 32'hF7);
    cmd_ready = '1;
    step();
    cmd_ready = '0;
    cpl_valid = 8'h77;
    step();
    cpl_valid = '0;
    step();
    chk("R9 no done", 32'(done), 32'd0);
    chk("R9 still busy", 32'(req_ready), 32'd0);
    cpl_valid = 8'h80;
    step();
    cpl_valid = '0;
    chk("R6 not early", 32'(done), 32'd0);
    step();
    chk("R6 done", 32'(done), 32'd1);
    step();

    // R7: error on one row
    send(32'h0000_0040, 3'd0);
    cmd_ready = '1;
    step();
    cmd_ready = '0;
    cpl_valid = '1;
    cpl_err   = 8'h04;
    step();
    cpl_valid = '0;
    cpl_err   = '0;
    step();
    chk("R7 err", 32'(err), 32'd1);
    chk("R7 no done", 32'(done), 32'd0);
    chk("R7 ready", 32'(req_ready), 32'd1);
    step();
    chk("R7 err pulse", 32'(err), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule